// File: doc/BRIEF.md
# Wake-up Event Router

This block gathers up to 32 single-bit event lines, for example external wake pins and internal peripheral event signals, and turns them into one interrupt line and one wake request. Every line first crosses a two-flop synchroniser and is then watched by its own detector. Two configuration bits per line choose one of four detector modes: LOW_LEVEL, HIGH_LEVEL, FALL_EDGE or RISE_EDGE. The edge modes compare the present synchronised sample with the one before it, kept in a per-line history flop.

A detected event sets that line's bit in a status register. The status is masked by an enable register and ORed into a registered interrupt output. A second registered output, the wake request, covers only the lines that a parameter marks as wake inputs. The status and enable registers are never written directly. Software changes them through separate set-bit and clear-bit addresses on a plain register port that has an address, write data, a write strobe and combinational read data.

The detector mode has four transitions. On a configuration write it moves to the newly decoded mode. On every clock it updates its history sample. From LOW_LEVEL or HIGH_LEVEL it raises a hit while the active level is present. From FALL_EDGE or RISE_EDGE it raises a hit on the matching change of the sample.

Top module: `wer_router`

## Requirements
- R1: Bit i of the polarity register (offset 0x000) and bit i of the edge-select register (offset 0x004) set the mode of input i. With polarity 0 and edge-select 0 the mode is low level. Polarity 1 and edge-select 0 gives high level. Polarity 0 and edge-select 1 gives falling edge. Polarity 1 and edge-select 1 gives rising edge.
- R2: An input change that is first sampled at rising edge k sets its status bit at edge k+2 and drives the interrupt at edge k+3.
- R3: In a level mode the status bit is set on every cycle in which the active level is present, including the cycle of a clear-status write. Once the level has gone, the bit stays set until it is cleared.
- R4: In an edge mode the status bit stays set after the edge until a clear-status write (0xFE8) clears it. The opposite edge does not set it.
- R5: A write to 0xFDC sets enable bits and a write to 0xFD8 clears them. A write to 0xFEC sets status bits and a write to 0xFE8 clears them. In each of these writes a 1 in a data bit acts on that bit and a 0 leaves it unchanged.
- R6: If a detector hit and a clear-status write reach the same bit in the same cycle, the bit ends up set.
- R7: The interrupt output is the OR of status AND enable over all bits, registered for one cycle.
- R8: The wake request is the registered OR of status AND enable over the lines marked by the wake mask (default: inputs 0 to 3). It never asserts without the interrupt.
- R9: Reset leaves the following values: polarity, edge-select and enable at 0, status at 0x03FDFFFF, and the interrupt and wake request low.
- R10: Reads return polarity at 0x000, edge-select at 0x004, status at 0xFE0 and enable at 0xFE4. The write-only and reserved addresses read as 0. Writes to 0xFE0, 0xFE4 or reserved space change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | NUM_EVT | Raw event lines, asynchronous |
| addr | input | 12 | Byte offset of the register access |
| wdata | input | NUM_EVT | Write data |
| we | input | 1 | Write strobe, one cycle per write |
| rdata | output | NUM_EVT | Read data for `addr`, combinational |
| irq | output | 1 | Registered event interrupt |
| wake_req | output | 1 | Registered wake request |

## Verification
The bench builds the router with its defaults: 32 lines, the stated status reset value and a wake mask of lines 0 to 3. Every bit position is therefore reachable, including line 31 at the top of the word. With this build an enabled wake line (line 0) and an enabled non-wake line (line 20) can be set side by side to tell the interrupt apart from the wake request. The vector table runs all four detector modes on different lines, each with a matching and a non-matching transition. Directed tests then cover the exact cycle timing and the case where a detector hit and a clear-status write reach the same bit together.

// File: rtl/wer_pkg.sv
package wer_pkg;

    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_POL     = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_EDGE    = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR  = 12'hFD8;
    localparam logic [ADDR_W-1:0] OFS_EN_SET  = 12'hFDC;
    localparam logic [ADDR_W-1:0] OFS_STAT    = 12'hFE0;
    localparam logic [ADDR_W-1:0] OFS_EN      = 12'hFE4;
    localparam logic [ADDR_W-1:0] OFS_ST_CLR  = 12'hFE8;
    localparam logic [ADDR_W-1:0] OFS_ST_SET  = 12'hFEC;

    // detector mode, encoded as {edge_select, polarity}
    typedef enum logic [1:0] {
        MODE_LOW_LEVEL  = 2'b00,
        MODE_HIGH_LEVEL = 2'b01,
        MODE_FALL_EDGE  = 2'b10,
        MODE_RISE_EDGE  = 2'b11
    } det_mode_e;

endpackage

// File: rtl/wer_sync.sv
module wer_sync #(
    parameter int WIDTH = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q[s] <= '0;
            end else begin
                if (s == 0) chain_q[s] <= raw_i;
                else        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/wer_detect.sv
module wer_detect
    import wer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smp_i,
    input  logic pol_i,
    input  logic edge_i,
    output logic hit_o
);

    logic      prev_q;
    det_mode_e mode;

    // history sample for the edge modes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= smp_i;
    end

    assign mode = det_mode_e'({edge_i, pol_i});

    always_comb begin
        hit_o = 1'b0;
        unique case (mode)
            MODE_LOW_LEVEL:  hit_o = !smp_i;
            MODE_HIGH_LEVEL: hit_o = smp_i;
            MODE_FALL_EDGE:  hit_o = prev_q && !smp_i;
            MODE_RISE_EDGE:  hit_o = !prev_q && smp_i;
            default:         hit_o = 1'b0;
        endcase
    end

    AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_i && hit_o) |-> (smp_i != prev_q)); // R4

endmodule

// File: rtl/wer_regs.sv
module wer_regs
    import wer_pkg::*;
#(
    parameter int NUM_EVT = 32,
    parameter logic [NUM_EVT-1:0] STAT_RST = 32'h03FD_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_EVT-1:0] wdata,
    input  logic               we,
    input  logic [NUM_EVT-1:0] hit_i,
    output logic [NUM_EVT-1:0] pol_o,
    output logic [NUM_EVT-1:0] edge_o,
    output logic [NUM_EVT-1:0] stat_o,
    output logic [NUM_EVT-1:0] en_o,
    output logic [NUM_EVT-1:0] rdata
);

    logic [NUM_EVT-1:0] pol_q, edge_q, en_q, stat_q;
    logic [NUM_EVT-1:0] en_n, stat_n;
    logic wr_pol, wr_edge, wr_en_set, wr_en_clr, wr_st_set, wr_st_clr;

    assign wr_pol    = we && (addr == OFS_POL);
    assign wr_edge   = we && (addr == OFS_EDGE);
    assign wr_en_set = we && (addr == OFS_EN_SET);
    assign wr_en_clr = we && (addr == OFS_EN_CLR);
    assign wr_st_set = we && (addr == OFS_ST_SET);
    assign wr_st_clr = we && (addr == OFS_ST_CLR);

    always_comb begin
        en_n = en_q;
        if (wr_en_set) en_n = en_n | wdata;
        if (wr_en_clr) en_n = en_n & ~wdata;
    end

    // hardware hits are ORed in last so they override a clear
    always_comb begin
        stat_n = stat_q;
        if (wr_st_clr) stat_n = stat_n & ~wdata;
        if (wr_st_set) stat_n = stat_n | wdata;
        stat_n = stat_n | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q  <= '0;
            edge_q <= '0;
            en_q   <= '0;
            stat_q <= STAT_RST;
        end else begin
            if (wr_pol)  pol_q  <= wdata;
            if (wr_edge) edge_q <= wdata;
            en_q   <= en_n;
            stat_q <= stat_n;
        end
    end

    always_comb begin
        unique case (addr)
            OFS_POL:  rdata = pol_q;
            OFS_EDGE: rdata = edge_q;
            OFS_STAT: rdata = stat_q;
            OFS_EN:   rdata = en_q;
            default:  rdata = '0;
        endcase
    end

    assign pol_o  = pol_q;
    assign edge_o = edge_q;
    assign stat_o = stat_q;
    assign en_o   = en_q;

    AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_i) |=> ((stat_q & $past(hit_i)) == $past(hit_i))); // R6

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_st_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R4

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_set || wr_en_clr) |=> $stable(en_q)); // R5

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pol || wr_edge) |=> ($stable(pol_q) && $stable(edge_q))); // R10

endmodule

// File: rtl/wer_irq.sv
module wer_irq #(
    parameter int NUM_EVT = 32,
    parameter logic [NUM_EVT-1:0] WAKE_MASK = 32'h0000_000F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] stat_i,
    input  logic [NUM_EVT-1:0] en_i,
    output logic               irq_o,
    output logic               wake_o
);

    logic [NUM_EVT-1:0] pend;
    logic irq_q, wake_q;

    assign pend = stat_i & en_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            irq_q  <= |pend;
            wake_q <= |(pend & WAKE_MASK);
        end
    end

    assign irq_o  = irq_q;
    assign wake_o = wake_q;

    AST_IRQ_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_i & en_i)) |=> irq_o); // R7

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_i & en_i)) |=> !irq_o); // R7

    AST_WAKE_IMPLIES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> irq_o); // R8

endmodule

// File: rtl/wer_router.sv
module wer_router
    import wer_pkg::*;
#(
    parameter int NUM_EVT = 32,
    parameter int SYNC_STAGES = 2,
    parameter logic [NUM_EVT-1:0] STAT_RST  = 32'h03FD_FFFF,
    parameter logic [NUM_EVT-1:0] WAKE_MASK = 32'h0000_000F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic [11:0]        addr,
    input  logic [NUM_EVT-1:0] wdata,
    input  logic               we,
    output logic [NUM_EVT-1:0] rdata,
    output logic               irq,
    output logic               wake_req
);

    logic [NUM_EVT-1:0] smp, hit, pol, edg, stat, en;

    wer_sync #(.WIDTH(NUM_EVT), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (evt_in),
        .sync_o (smp)
    );

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_det
        wer_detect u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp_i  (smp[i]),
            .pol_i  (pol[i]),
            .edge_i (edg[i]),
            .hit_o  (hit[i])
        );
    end

    wer_regs #(.NUM_EVT(NUM_EVT), .STAT_RST(STAT_RST)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .wdata  (wdata),
        .we     (we),
        .hit_i  (hit),
        .pol_o  (pol),
        .edge_o (edg),
        .stat_o (stat),
        .en_o   (en),
        .rdata  (rdata)
    );

    wer_irq #(.NUM_EVT(NUM_EVT), .WAKE_MASK(WAKE_MASK)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat),
        .en_i   (en),
        .irq_o  (irq),
        .wake_o (wake_req)
    );

endmodule

// File: tb/wer_router_tb.sv
module wer_router_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] A_POL = 12'h000, A_EDGE = 12'h004, A_ENCLR = 12'hFD8,
                            A_ENSET = 12'hFDC, A_STAT = 12'hFE0, A_EN = 12'hFE4,
                            A_STCLR = 12'hFE8, A_STSET = 12'hFEC;

    // {channel[11:7], pol, edge, v_before, v_after, exp_pre, exp_post, exp_after_clear}
    localparam logic [11:0] VEC [0:7] = '{
        {5'd0,  7'b1001011},
        {5'd1,  7'b0010011},
        {5'd2,  7'b0110010},
        {5'd3,  7'b1101010},
        {5'd4,  7'b1110000},
        {5'd5,  7'b0101000},
        {5'd31, 7'b1010110},
        {5'd17, 7'b0010011}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] evt_in = '0;
    logic [11:0] addr = A_STAT;
    logic [31:0] wdata = '0;
    logic we = 1'b0;
    logic [31:0] rdata;
    logic irq, wake_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [31:0] pol_sh, edge_sh;

    always #(CLK_PERIOD/2) clk = ~clk;

    wer_router dut_i (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .addr(addr),
        .wdata(wdata), .we(we), .rdata(rdata), .irq(irq), .wake_req(wake_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = A_STAT; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
        addr = A_STAT;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        // ---- reset values (R9, R10)
        #(CLK_PERIOD*2 + 2);
        rd(A_STAT, r);  check("R9 status reset", r, 32'h03FD_FFFF);
        rd(A_POL, r);   check("R9 polarity reset", r, 32'h0);
        rd(A_EDGE, r);  check("R9 edge reset", r, 32'h0);
        rd(A_EN, r);    check("R9 enable reset", r, 32'h0);
        check("R9 irq/wake reset", {30'd0, irq, wake_req}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // idle config: high level on every line, inputs low
        pol_sh = '1; edge_sh = '0;
        wr(A_POL, pol_sh); wr(A_EDGE, edge_sh);
        idle(4);
        wr(A_STCLR, '1);
        rd(A_STAT, r);  check("R5 clear all status", r, 32'h0);
        rd(A_POL, r);   check("R10 polarity readback", r, 32'hFFFF_FFFF);

        // ---- vector walk over the four modes (R1, R3, R4)
        for (int v = 0; v < 8; v++) begin
            int ch;
            ch = int'(VEC[v][11:7]);
            evt_in[ch] = VEC[v][4];
            idle(4);
            pol_sh[ch] = VEC[v][6]; edge_sh[ch] = VEC[v][5];
            wr(A_POL, pol_sh); wr(A_EDGE, edge_sh);
            wr(A_STCLR, 32'h1 << ch);
            rd(A_STAT, r); check($sformatf("R1/R3 vec%0d before", v), {31'd0, r[ch]}, {31'd0, VEC[v][2]});
            evt_in[ch] = VEC[v][3];
            idle(4);
            rd(A_STAT, r); check($sformatf("R1/R4 vec%0d after change", v), {31'd0, r[ch]}, {31'd0, VEC[v][1]});
            wr(A_STCLR, 32'h1 << ch);
            rd(A_STAT, r); check($sformatf("R3/R4 vec%0d after clear", v), {31'd0, r[ch]}, {31'd0, VEC[v][0]});
            pol_sh[ch] = 1'b1; edge_sh[ch] = 1'b0;
            wr(A_POL, pol_sh); wr(A_EDGE, edge_sh);
            evt_in[ch] = 1'b0;
            idle(4);
            wr(A_STCLR, '1);
        end
        rd(A_STAT, r); check("R4 status clean after walk", r, 32'h0);

        // ---- exact timing, interrupt and wake (R2, R7, R8)
        wr(A_ENSET, 32'h0010_0001);
        rd(A_EN, r); check("R5 enable set", r, 32'h0010_0001);
        @(negedge clk); evt_in[0] = 1'b1;     // sampled at edge k
        @(negedge clk);                       // after k
        @(negedge clk);                       // after k+1
        rd(A_STAT, r); check("R2 status not yet at k+1", r, 32'h0);
        @(negedge clk);                       // after k+2
        rd(A_STAT, r); check("R2 status set at k+2", r, 32'h1);
        check("R2 irq not yet at k+2", {31'd0, irq}, 32'h0);
        @(negedge clk);                       // after k+3
        check("R2 R7 irq at k+3", {31'd0, irq}, 32'h1);
        check("R8 wake on line 0", {31'd0, wake_req}, 32'h1);
        evt_in[0] = 1'b0;
        idle(4);
        wr(A_STCLR, 32'h1);
        @(negedge clk);
        check("R7 irq drops after clear", {31'd0, irq}, 32'h0);

        wr(A_STSET, 32'h0010_0000);
        @(negedge clk);
        check("R7 irq from non-wake line", {31'd0, irq}, 32'h1);
        check("R8 no wake from line 20", {31'd0, wake_req}, 32'h0);
        wr(A_ENCLR, 32'h0010_0000);
        @(negedge clk);
        check("R5 irq off after enable clear", {31'd0, irq}, 32'h0);
        rd(A_EN, r);   check("R5 enable bit0 untouched", r, 32'h1);
        rd(A_STAT, r); check("R5 status kept on enable clear", r, 32'h0010_0000);

        // ---- set/clear with mixed data (R5)
        wr(A_ENSET, 32'h5); wr(A_ENSET, 32'h2);
        rd(A_EN, r); check("R5 enable set merge", r, 32'h7);
        wr(A_ENCLR, 32'h4);
        rd(A_EN, r); check("R5 enable clear partial", r, 32'h3);
        wr(A_ENCLR, '1);

        // ---- ignored writes and zero reads (R10)
        wr(A_STAT, 32'h0);
        rd(A_STAT, r);  check("R10 status write ignored", r, 32'h0010_0000);
        wr(12'h100, 32'h0);
        rd(12'h100, r); check("R10 reserved reads zero", r, 32'h0);
        rd(A_POL, r);   check("R10 reserved write ignored", r, 32'hFFFF_FFFF);
        rd(A_STCLR, r); check("R10 write-only reads zero", r, 32'h0);
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, r);    check("R10 enable direct write ignored", r, 32'h0);
        wr(A_STCLR, '1);

        // ---- hit and clear in the same cycle (R6), line 2 rising edge
        edge_sh[2] = 1'b1;
        wr(A_EDGE, edge_sh);
        rd(A_STAT, r); check("R6 line 2 idle", r, 32'h0);
        @(negedge clk); evt_in[2] = 1'b1;      // edge k
        @(negedge clk);                        // after k
        @(negedge clk);                        // after k+1, hit now high
        addr = A_STCLR; wdata = 32'h4; we = 1'b1;
        @(negedge clk);                        // after k+2
        we = 1'b0; addr = A_STAT; wdata = '0;
        rd(A_STAT, r); check("R6 hit beats clear", r, 32'h4);
        wr(A_STCLR, 32'h4);
        rd(A_STAT, r); check("R4 edge bit cleared afterwards", r, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule